// File: doc/BRIEF.md
# Drink Vending Credit Controller

This block is the control core of a simple drink dispenser that sells one drink at a fixed price of 15 cents. Two coin inputs pulse when a 5-cent or a 10-cent coin has been accepted. A drink request input asks for a drink. A money-back input asks for the credit to be returned. The controller keeps the credit as one of four levels: 0, 5, 10, or 15 cents and above.

A drink is released only on an explicit request. Credit comes back only on an explicit money-back request, through one of three fixed-amount refund lines. A coin that would raise the credit above the price is paid back at once on the refund line that matches the excess.

Every output comes from a flip-flop, so no pulse can glitch. Each pulse appears one clock after the edge that samples the request and lasts one cycle. The credit level is held in a one-hot register. Any encoding outside the four legal codes falls back to the empty-credit state.

Top module: `vend_ctrl`

## Requirements
- R1: After a synchronous reset the credit is zero and every output is low. Any credit-register encoding other than the four legal one-hot codes moves to the zero-credit state on the next clock, with no output pulse.
- R2: A 5-cent coin pulse adds one credit step of 5 cents. A 10-cent coin pulse adds two steps, 10 cents.
- R3: A coin that would take the credit above 15 cents leaves the credit at 15 cents. The excess is returned at once as a refund pulse for that excess: 5 cents on `refund_o[0]`, 10 cents on `refund_o[1]`.
- R4: A drink request while the credit is 15 cents pulses `dispense_o` for one cycle and clears the credit to zero.
- R5: A drink request while the credit is below 15 cents produces no pulse and leaves the credit unchanged.
- R6: A money-back request with nonzero credit pulses the refund bit that matches the credit and clears the credit. The bits are `refund_o[0]` for 5 cents, `refund_o[1]` for 10 cents and `refund_o[2]` for 15 cents. With zero credit the request produces nothing.
- R7: When several inputs are high in one cycle, only the highest-priority one is acted on and the others are dropped. The priority order is: money-back, then drink request, then 10-cent coin, then 5-cent coin.
- R8: An output pulse is high in the clock cycle after the edge that samples its request, and low again one cycle later.
- R9: At most one of `dispense_o` and the `refund_o` bits is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin5_i | input | 1 | One-cycle pulse: 5-cent coin accepted |
| coin10_i | input | 1 | One-cycle pulse: 10-cent coin accepted |
| vend_i | input | 1 | Drink request |
| refund_i | input | 1 | Money-back request |
| dispense_o | output | 1 | One-cycle pulse: release a drink |
| refund_o | output | LEVELS-1 | One-cycle refund pulses; bit k returns 5*(k+1) cents |

## Verification
A money-back request, a drink request and a coin can all be sampled on the same edge. Each of these actions changes the credit in a different way. The bench provokes these collisions by raising several inputs in one cycle at different credit levels, including with all four inputs high at once.

Each collision is judged in two steps. First, the single output pulse that follows must belong to the winning input. Second, a later money-back request reveals the remaining credit, which must show that the losing inputs were dropped and not added.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_REFUND,
    ACT_VEND,
    ACT_COIN_HI,
    ACT_COIN_LO
  } act_e;
endpackage

// File: rtl/vend_arb.sv
module vend_arb
  import vend_pkg::*;
(
  input  logic coin5_i,
  input  logic coin10_i,
  input  logic vend_i,
  input  logic refund_i,
  output act_e act_o
);
  always_comb begin
    if (refund_i)      act_o = ACT_REFUND;
    else if (vend_i)   act_o = ACT_VEND;
    else if (coin10_i) act_o = ACT_COIN_HI;
    else if (coin5_i)  act_o = ACT_COIN_LO;
    else               act_o = ACT_NONE;
  end
endmodule

// File: rtl/vend_step.sv
module vend_step
  import vend_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int RW    = LEVELS - 1,
  localparam int TOP   = LEVELS - 1
) (
  input  logic [LEVELS-1:0] state_q,
  input  act_e              act_i,
  output logic [LEVELS-1:0] state_d,
  output logic              dispense_d,
  output logic [RW-1:0]     refund_d,
  output logic              valid_o
);
  int cnt;
  int lvl;
  int nxt;
  int sum;

  always_comb begin
    cnt = 0;
    lvl = 0;
    for (int i = 0; i < LEVELS; i++) begin
      if (state_q[i]) begin
        cnt = cnt + 1;
        lvl = i;
      end
    end
    valid_o    = (cnt == 1);
    nxt        = lvl;
    sum        = 0;
    dispense_d = 1'b0;
    refund_d   = '0;
    if (!valid_o) begin
      nxt = 0;
    end else begin
      case (act_i)
        ACT_REFUND: begin
          if (lvl != 0) begin
            refund_d[lvl-1] = 1'b1;
            nxt = 0;
          end
        end
        ACT_VEND: begin
          if (lvl == TOP) begin
            dispense_d = 1'b1;
            nxt = 0;
          end
        end
        ACT_COIN_HI, ACT_COIN_LO: begin
          sum = lvl + ((act_i == ACT_COIN_HI) ? 2 : 1);
          if (sum > TOP) begin
            nxt = TOP;
            refund_d[sum-TOP-1] = 1'b1;
          end else begin
            nxt = sum;
          end
        end
        default: nxt = lvl;
      endcase
    end
    for (int i = 0; i < LEVELS; i++) state_d[i] = (nxt == i);
  end
endmodule

// File: rtl/vend_outreg.sv
module vend_outreg #(
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dispense_d,
  input  logic [RW-1:0] refund_d,
  output logic          dispense_o,
  output logic [RW-1:0] refund_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dispense_o <= 1'b0;
      refund_o   <= '0;
    end else begin
      dispense_o <= dispense_d;
      refund_o   <= refund_d;
    end
  end

  AST_SINGLE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dispense_o, refund_o})); // R9
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int RW    = LEVELS - 1,
  localparam int TOP   = LEVELS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          coin5_i,
  input  logic          coin10_i,
  input  logic          vend_i,
  input  logic          refund_i,
  output logic          dispense_o,
  output logic [RW-1:0] refund_o
);
  localparam logic [LEVELS-1:0] START = LEVELS'(1);

  logic [LEVELS-1:0] state_q;
  logic [LEVELS-1:0] state_d;
  logic              dispense_d;
  logic [RW-1:0]     refund_d;
  logic              valid;
  act_e              act;

  vend_arb i_arb (
    .coin5_i  (coin5_i),
    .coin10_i (coin10_i),
    .vend_i   (vend_i),
    .refund_i (refund_i),
    .act_o    (act)
  );

  vend_step #(.LEVELS(LEVELS)) i_step (
    .state_q    (state_q),
    .act_i      (act),
    .state_d    (state_d),
    .dispense_d (dispense_d),
    .refund_d   (refund_d),
    .valid_o    (valid)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= START;
    else     state_q <= state_d;
  end

  vend_outreg #(.RW(RW)) i_outreg (
    .clk        (clk),
    .rst        (rst),
    .dispense_d (dispense_d),
    .refund_d   (refund_d),
    .dispense_o (dispense_o),
    .refund_o   (refund_o)
  );

  AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (state_q == START) && !dispense_o && (refund_o == '0)); // R1
  AST_REFUND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    refund_i |=> state_q == START); // R6
  AST_VEND_FULL: assert property (@(posedge clk) disable iff (rst)
    (vend_i && !refund_i && state_q == (START << TOP)) |=> dispense_o && state_q == START); // R4
  AST_VEND_SHORT: assert property (@(posedge clk) disable iff (rst)
    (vend_i && !refund_i && valid && !state_q[TOP]) |=> !dispense_o && $stable(state_q)); // R5
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dispense_o |=> !dispense_o); // R8
endmodule

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin5 = 1'b0;
  logic       coin10 = 1'b0;
  logic       vend = 1'b0;
  logic       refund = 1'b0;
  logic       dispense;
  logic [2:0] ret;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  vend_ctrl #(.LEVELS(4)) i_vend_ctrl (
    .clk        (clk),
    .rst        (rst),
    .coin5_i    (coin5),
    .coin10_i   (coin10),
    .vend_i     (vend),
    .refund_i   (refund),
    .dispense_o (dispense),
    .refund_o   (ret)
  );

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got {disp,ret}=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(input logic c5, input logic c10, input logic vd, input logic rf,
                       input logic [3:0] exp, input string tag);
    @(negedge clk);
    coin5 = c5; coin10 = c10; vend = vd; refund = rf;
    @(posedge clk);
    @(negedge clk);
    coin5 = 1'b0; coin10 = 1'b0; vend = 1'b0; refund = 1'b0;
    check({dispense, ret}, exp, tag);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({dispense, ret}, 4'b0000, "R1 outputs low in reset");
    rst = 1'b0;
    apply(0, 0, 0, 1, 4'b0000, "R1 credit zero after reset (R6 none at zero)");
  endtask

  task automatic t_coins;
    apply(1, 0, 0, 0, 4'b0000, "R2 coin5 no pulse");
    apply(0, 0, 0, 1, 4'b0001, "R2 R6 credit 5 refunded on bit0");
    apply(0, 1, 0, 0, 4'b0000, "R2 coin10 no pulse");
    apply(0, 0, 0, 1, 4'b0010, "R2 R6 credit 10 refunded on bit1");
    apply(1, 0, 0, 0, 4'b0000, "R2 coin5");
    apply(1, 0, 0, 0, 4'b0000, "R2 coin5 again");
    apply(0, 0, 0, 1, 4'b0010, "R2 two coin5 make 10");
    apply(1, 0, 0, 0, 4'b0000, "R2 coin5");
    apply(0, 1, 0, 0, 4'b0000, "R2 coin10 to 15");
    apply(0, 0, 0, 1, 4'b0100, "R6 credit 15 refunded on bit2");
  endtask

  task automatic t_vend;
    apply(0, 1, 0, 0, 4'b0000, "R4 load 10");
    apply(1, 0, 0, 0, 4'b0000, "R4 load 15");
    @(negedge clk);
    vend = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vend = 1'b0;
    check({dispense, ret}, 4'b1000, "R4 R8 dispense one cycle after request");
    @(negedge clk);
    check({dispense, ret}, 4'b0000, "R8 dispense low next cycle");
    apply(0, 0, 0, 1, 4'b0000, "R4 credit cleared by dispense");
  endtask

  task automatic t_vend_short;
    apply(0, 1, 0, 0, 4'b0000, "R5 load 10");
    apply(0, 0, 1, 0, 4'b0000, "R5 no dispense below price");
    apply(0, 0, 0, 1, 4'b0010, "R5 credit kept at 10");
  endtask

  task automatic t_overflow;
    apply(0, 1, 0, 0, 4'b0000, "R3 load 10");
    apply(0, 1, 0, 0, 4'b0001, "R3 10+10 returns 5");
    apply(0, 0, 0, 1, 4'b0100, "R3 credit held at 15");
    apply(0, 1, 0, 0, 4'b0000, "R3 load 10");
    apply(1, 0, 0, 0, 4'b0000, "R3 load 15");
    apply(0, 1, 0, 0, 4'b0010, "R3 15+10 returns 10");
    apply(1, 0, 0, 0, 4'b0001, "R3 15+5 returns 5");
    apply(0, 0, 1, 0, 4'b1000, "R3 R4 still 15 so dispense");
    apply(0, 0, 0, 1, 4'b0000, "R3 credit empty after dispense");
  endtask

  task automatic t_priority;
    apply(0, 1, 0, 0, 4'b0000, "R7 load 10");
    apply(1, 1, 1, 1, 4'b0010, "R7 refund wins over all");
    apply(0, 0, 0, 1, 4'b0000, "R7 coins dropped under refund");
    apply(0, 1, 0, 0, 4'b0000, "R7 load 10");
    apply(1, 0, 0, 0, 4'b0000, "R7 load 15");
    apply(1, 1, 1, 0, 4'b1000, "R7 vend wins over coins");
    apply(0, 0, 0, 1, 4'b0000, "R7 coins dropped under vend");
    apply(1, 1, 0, 0, 4'b0000, "R7 coin10 wins over coin5");
    apply(0, 0, 0, 1, 4'b0010, "R7 only 10 credited");
    apply(0, 1, 0, 1, 4'b0000, "R7 refund at zero drops coin");
    apply(0, 0, 0, 1, 4'b0000, "R7 credit still zero");
    apply(0, 1, 0, 0, 4'b0000, "R7 load 10");
    apply(0, 0, 1, 1, 4'b0010, "R7 refund beats vend below price");
    checks++;
    if ($countones({dispense, ret}) > 1) begin
      errors++;
      $display("FAIL R9: got %b expected at most one bit", {dispense, ret});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_coins();
    t_vend();
    t_vend_short();
    t_overflow();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule